// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block is one performance event counter together with the 32-bit configuration word that chooses what it counts. Every clock it sees a vector of event pulses, the current privilege level (0 to 3) and a flag that says whether the processor is in the secure state. When the event that the configuration selects pulses, and the filter bits allow counting at that level and security state, the 32-bit count goes up by one.

The configuration word is written through a one-cycle write strobe and can always be read back. The count can be loaded and read. When the count wraps past its maximum, a sticky overflow flag is set. The event-number field only accepts numbers from a parameterised supported window. For other numbers, the value that reads back depends on which range the number falls in. Bit 25 is stored and read back but has no effect on counting.

Top module: `evfilt_counter`

## Requirements
- R1: After reset, the configuration readback, the count and the overflow flag are all zero.
- R2: Bits 23:16 of the configuration always read as zero, whatever was written. Bits 31:24, including the stored-only bit 25, read back as written.
- R3: The event number is held in bits 15:0. A supported number reads back as written. The supported numbers are SUP_BASE to SUP_BASE+NUM_EVT-1 (0x0010 to 0x0017 by default). An unsupported number in 0x0000–0x003F or 0x4000–0x403F also reads back as written. Any other unsupported number reads back as zero. No unsupported number ever causes counting.
- R4: The count rises by one at the clock edge that ends a cycle in which three conditions hold. The pulse line at index (number − SUP_BASE) is high, the number is supported, and the filter allows counting. Otherwise the count holds.
- R5: At level 0, counting in the secure state requires bit 30 = 0. In the non-secure state it requires bit 28 = bit 30.
- R6: At level 1, counting in the secure state requires bit 31 = 0. In the non-secure state it requires bit 29 = bit 31.
- R7: At level 2, counting in the non-secure state requires bit 27 = 1. In the secure state it requires bit 24 ≠ bit 27.
- R8: At level 3, counting requires bit 26 = bit 31 in either security state.
- R9: A configuration write takes effect from the next cycle. The cycle that carries the write is filtered with the old configuration.
- R10: A count load replaces the count at the next edge and overrides any increment in that cycle.
- R11: An increment from 0xFFFFFFFF gives 0 and sets the overflow flag. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write value |
| cfg_rd_data | output | 32 | Configuration readback |
| cnt_wr_en | input | 1 | Count load strobe |
| cnt_wr_data | input | CNT_W | Count load value |
| evt_pulse | input | NUM_EVT | Event pulse lines, one per supported number |
| cur_level | input | 2 | Current privilege level |
| secure | input | 1 | 1 when the processor is in the secure state |
| count | output | CNT_W | Event count |
| overflow | output | 1 | Sticky wrap flag |

## Verification
The assertions assume that the event pulses, the level, the security flag and both write strobes are stable and defined across each clock edge while reset is released. The bench drives all of them only at the falling edge. They also assume that the configuration readback shows the same word the filter uses, which holds because both come from one register. The stimulus sweeps all 128 combinations of the seven filter bits over every level and security state. It mixes random event numbers drawn from the supported window, both kept ranges and the discard region, and loads the count close to its maximum so that the wrap is reached.

// File: rtl/evfilt_pkg.sv
package evfilt_pkg;

  typedef struct packed {
    logic        priv_off;   // 31 suppress level 1
    logic        user_off;   // 30 suppress level 0
    logic        ns_priv;    // 29 non-secure level 1 pair bit
    logic        ns_user;    // 28 non-secure level 0 pair bit
    logic        hyp_on;     // 27 level 2 enable
    logic        mon_pair;   // 26 level 3 pair bit
    logic        mthread;    // 25 stored only
    logic        s_hyp;      // 24 secure level 2 pair bit
    logic [7:0]  resv;       // 23:16 always zero
    logic [15:0] evnum;      // 15:0 event number
  } cfg_t;

  function automatic logic level_allows(input cfg_t c, input logic [1:0] lvl,
                                        input logic sec);
    logic ok;
    case (lvl)
      2'd0:    ok = sec ? !c.user_off : (c.ns_user == c.user_off);
      2'd1:    ok = sec ? !c.priv_off : (c.ns_priv == c.priv_off);
      2'd2:    ok = sec ? (c.s_hyp != c.hyp_on) : c.hyp_on;
      default: ok = (c.mon_pair == c.priv_off);
    endcase
    return ok;
  endfunction

  function automatic logic in_keep_range(input logic [15:0] n);
    return (n[15:6] == 10'h000) || (n[15:6] == 10'h100);
  endfunction

endpackage

// File: rtl/evfilt_cfg_reg.sv
module evfilt_cfg_reg
  import evfilt_pkg::*;
#(
  parameter int          NUM_EVT  = 8,
  parameter logic [15:0] SUP_BASE = 16'h0010,
  localparam int         IDX_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output cfg_t             cfg_q,
  output logic             sel_ok,
  output logic [IDX_W-1:0] sel_idx
);
  localparam logic [16:0] NUM_EVT17 = 17'(NUM_EVT);

  cfg_t        wr_cfg;
  logic [15:0] wr_off;
  logic        wr_sup;
  logic        wr_keep;

  always_comb begin
    wr_cfg  = cfg_t'(wr_data);
    wr_off  = wr_cfg.evnum - SUP_BASE;
    wr_sup  = (wr_cfg.evnum >= SUP_BASE) && ({1'b0, wr_off} < NUM_EVT17);
    wr_keep = wr_sup || in_keep_range(wr_cfg.evnum);
    wr_cfg.resv = '0;
    if (!wr_keep) wr_cfg.evnum = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      sel_ok  <= 1'b0;
      sel_idx <= '0;
    end else if (wr_en) begin
      cfg_q   <= wr_cfg;
      sel_ok  <= wr_sup;
      sel_idx <= wr_off[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/evfilt_gate.sv
module evfilt_gate
  import evfilt_pkg::*;
#(
  parameter int  NUM_EVT = 8,
  localparam int IDX_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  cfg_t               cfg,
  input  logic               sel_ok,
  input  logic [IDX_W-1:0]   sel_idx,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [1:0]         cur_level,
  input  logic               secure,
  output logic               inc
);
  logic line_hit;

  always_comb begin
    line_hit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++)
      if (sel_idx == IDX_W'(i)) line_hit = evt_pulse[i];
    inc = sel_ok && line_hit && level_allows(cfg, cur_level, secure);
  end
endmodule

// File: rtl/evfilt_count.sv
module evfilt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (ld_en) begin
      count <= ld_data;
    end else if (inc) begin
      count <= count + 1'b1;
      if (&count) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/evfilt_counter.sv
module evfilt_counter
  import evfilt_pkg::*;
#(
  parameter int          NUM_EVT  = 8,
  parameter logic [15:0] SUP_BASE = 16'h0010,
  parameter int          CNT_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [31:0]        cfg_wr_data,
  output logic [31:0]        cfg_rd_data,
  input  logic               cnt_wr_en,
  input  logic [CNT_W-1:0]   cnt_wr_data,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [1:0]         cur_level,
  input  logic               secure,
  output logic [CNT_W-1:0]   count,
  output logic               overflow
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  cfg_t             cfg_q;
  logic             sel_ok;
  logic [IDX_W-1:0] sel_idx;
  logic             inc_fire;

  evfilt_cfg_reg #(.NUM_EVT(NUM_EVT), .SUP_BASE(SUP_BASE)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg_q(cfg_q), .sel_ok(sel_ok), .sel_idx(sel_idx)
  );

  evfilt_gate #(.NUM_EVT(NUM_EVT)) gate_i (
    .cfg(cfg_q), .sel_ok(sel_ok), .sel_idx(sel_idx), .evt_pulse(evt_pulse),
    .cur_level(cur_level), .secure(secure), .inc(inc_fire)
  );

  evfilt_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .ld_en(cnt_wr_en), .ld_data(cnt_wr_data),
    .inc(inc_fire), .count(count), .overflow(overflow)
  );

  assign cfg_rd_data = cfg_q;
endmodule

// File: rtl/evfilt_counter_chk.sv
module evfilt_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic [1:0]       cur_level,
  input logic             secure,
  input logic [31:0]      cfg_rd_data,
  input logic [CNT_W-1:0] count,
  input logic             overflow,
  input logic             inc_fire
);
  a_r2_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[23:16] == 8'h00);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr_en && !inc_fire) |=> $stable(count));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr_en && inc_fire && !(&count)) |=> count == $past(count) + 1'b1);

  a_r6_secure_l1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && cur_level == 2'd1 && secure) |-> !cfg_rd_data[31]);

  a_r7_ns_l2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && cur_level == 2'd2 && !secure) |-> cfg_rd_data[27]);

  a_r8_l3_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && cur_level == 2'd3) |-> cfg_rd_data[26] == cfg_rd_data[31]);

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> count == $past(cnt_wr_data));

  a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr_en && inc_fire && (&count)) |=> (count == '0) && overflow);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind evfilt_counter evfilt_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
  .cur_level(cur_level), .secure(secure), .cfg_rd_data(cfg_rd_data),
  .count(count), .overflow(overflow), .inc_fire(inc_fire)
);

// File: tb/evfilt_counter_tb.sv
module evfilt_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        cnt_wr_en = 1'b0;
  logic [31:0] cnt_wr_data = '0;
  logic [7:0]  evt_pulse = '0;
  logic [1:0]  cur_level = '0;
  logic        secure = 1'b0;
  logic [31:0] count;
  logic        overflow;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [31:0] m_cfg = '0;
  logic        m_ok = 0;
  logic [2:0]  m_idx = '0;
  logic [31:0] m_cnt = '0;
  logic        m_ovf = 0;

  always #5 clk = ~clk;

  evfilt_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .evt_pulse(evt_pulse), .cur_level(cur_level), .secure(secure),
    .count(count), .overflow(overflow)
  );

  function automatic bit b_sup(input logic [15:0] n);
    return (n >= 16'h0010) && (n <= 16'h0017);
  endfunction

  function automatic logic [31:0] b_rd(input logic [31:0] w);
    logic [15:0] n = w[15:0];
    bit keep = b_sup(n) || (n <= 16'h003F) || (n >= 16'h4000 && n <= 16'h403F);
    return {w[31:24], 8'h00, keep ? n : 16'h0000};
  endfunction

  function automatic bit b_filt(input logic [31:0] c, input logic [1:0] l, input bit s);
    bit p = c[31], u = c[30], nk = c[29], nu = c[28], nh = c[27], m = c[26], sh = c[24];
    if (l == 2'd3) return !(m ^ p);
    if (l == 2'd2) return s ? (sh ^ nh) : nh;
    if (l == 2'd1) return s ? !p : !(nk ^ p);
    return s ? !u : !(nu ^ u);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit fire = m_ok && evt_pulse[m_idx] && b_filt(m_cfg, cur_level, secure);
    @(posedge clk);
    if (cnt_wr_en) m_cnt = cnt_wr_data;
    else if (fire) begin
      if (m_cnt == 32'hFFFF_FFFF) m_ovf = 1;
      m_cnt = m_cnt + 1;
    end
    if (cfg_wr_en) begin
      m_cfg = b_rd(cfg_wr_data);
      m_ok  = b_sup(cfg_wr_data[15:0]);
      m_idx = 3'(cfg_wr_data[15:0] - 16'h0010);
    end
    @(negedge clk);
    check({tag, " count"}, count, m_cnt);
    check({tag, " overflow"}, {31'b0, overflow}, {31'b0, m_ovf});
    check({tag, " cfg"}, cfg_rd_data, m_cfg);
  endtask

  task automatic wr_cfg(input logic [31:0] w, input string tag);
    cfg_wr_en = 1; cfg_wr_data = w; evt_pulse = '0;
    step(tag);
    cfg_wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset cfg", cfg_rd_data, 32'h0);
    check("R1 reset count", count, 32'h0);
    check("R1 reset ovf", {31'b0, overflow}, 32'h0);

    // R2: reserved field dropped, upper filter bits and bit 25 kept
    wr_cfg(32'hFFFF_0012, "R2 resv");
    check("R2 readback", cfg_rd_data, 32'hFF00_0012);
    wr_cfg(32'h02AA_0015, "R2 mt bit");
    check("R2 mt", cfg_rd_data, 32'h0200_0015);

    // R3: readback per range; unsupported never counts
    wr_cfg(32'h0000_0030, "R3 low range");
    check("R3 low", cfg_rd_data, 32'h0000_0030);
    evt_pulse = 8'hFF; step("R3 no count low");
    wr_cfg(32'h0000_4020, "R3 ext range");
    check("R3 ext", cfg_rd_data, 32'h0000_4020);
    evt_pulse = 8'hFF; step("R3 no count ext");
    wr_cfg(32'h0000_1234, "R3 discard");
    check("R3 discard", cfg_rd_data, 32'h0000_0000);
    evt_pulse = 8'hFF; step("R3 no count discard");
    check("R3 count held", count, 32'h0);

    // R9: write in a counting cycle uses old (blocking) config
    wr_cfg(32'hC000_0013, "R9 setup");
    cur_level = 2'd1; secure = 1; evt_pulse = 8'h08;
    cfg_wr_en = 1; cfg_wr_data = 32'h0000_0013;
    step("R9 old cfg");
    check("R9 no count on write cycle", count, 32'h0);
    cfg_wr_en = 0;
    step("R9 new cfg");
    check("R9 counts next cycle", count, 32'h1);

    // R5-R8: all filter combinations, every level and state
    for (int c = 0; c < 128; c++) begin
      logic [6:0] f = 7'(c);
      wr_cfg({f[6:1], 1'b0, f[0], 8'h00, 16'h0012}, "R5-8 setup");
      for (int l = 0; l < 4; l++)
        for (int s = 0; s < 2; s++) begin
          cur_level = 2'(l); secure = s[0]; evt_pulse = 8'h04;
          case (l)
            0: step("R5 level0");
            1: step("R6 level1");
            2: step("R7 level2");
            default: step("R8 level3");
          endcase
        end
    end

    // R10: load overrides increment
    wr_cfg(32'h0000_0010, "R10 setup");
    cur_level = 2'd0; secure = 1; evt_pulse = 8'h01;
    cnt_wr_en = 1; cnt_wr_data = 32'h1234_5678;
    step("R10 load");
    check("R10 loaded value", count, 32'h1234_5678);
    cnt_wr_en = 0;

    // R11: wrap and sticky flag
    cnt_wr_en = 1; cnt_wr_data = 32'hFFFF_FFFE; evt_pulse = 8'h00;
    step("R11 preload");
    cnt_wr_en = 0; evt_pulse = 8'h01;
    step("R11 to max");
    step("R11 wrap");
    check("R11 wrapped", count, 32'h0);
    check("R11 flag", {31'b0, overflow}, 32'h1);
    evt_pulse = 8'h00;
    cnt_wr_en = 1; cnt_wr_data = 32'h5;
    step("R11 sticky after load");
    cnt_wr_en = 0;
    check("R11 still set", {31'b0, overflow}, 32'h1);

    // Random mix (R4 and all filters)
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 19);
      cfg_wr_en = 0; cnt_wr_en = 0;
      if (k == 0) begin
        logic [15:0] n;
        case ($urandom_range(0, 3))
          0: n = 16'h0010 + 16'($urandom_range(0, 7));
          1: n = 16'($urandom_range(0, 63));
          2: n = 16'h4000 + 16'($urandom_range(0, 63));
          default: n = 16'($urandom);
        endcase
        cfg_wr_en = 1; cfg_wr_data = {8'($urandom), 8'($urandom), n};
      end else if (k == 1) begin
        cnt_wr_en = 1;
        cnt_wr_data = $urandom_range(0, 1) ? 32'hFFFF_FFF0 + 32'($urandom_range(0, 15)) : $urandom;
      end
      evt_pulse = 8'($urandom);
      cur_level = 2'($urandom);
      secure = 1'($urandom);
      step("R4 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule